// File: doc/BRIEF.md
# Packed Palette Loader RAM

This block is a 256-entry color lookup table. Each entry is 24 bits: 8 bits each of red, green and blue. Firmware loads it through four 32-bit word registers. It first writes a group base index to the address word. It then streams color bytes through the data word, four bytes per write, in the repeating order red, green, blue. A triple may start in one data word and end in the next, so three data writes carry exactly four entries.

The loader keeps a running entry index and a byte position inside the current triple. It commits each triple to the table in the cycle its blue byte arrives. It then advances the index, which wraps from 255 to 0. A stream that runs past twelve bytes simply carries on into the next group. The same address word also selects one register in a small bank of indirect 8-bit control registers, which are written and read through the control word.

A separate pixel port turns an 8-bit pixel index into its 24-bit color, registered, one clock later.

Top module: `clut_loader`

## Requirements
- R1: After reset the running entry index reads 0, every table entry looks up as 24'h000000, and pix_rgb_o is 0.
- R2: After reset, indirect control registers 4, 5, 6 and 7 hold 8'hFF, 8'h00, 8'h70 and 8'h00. All other control registers hold 8'h00.
- R3: A write to word 0 (reg_sel_i = 0) does two things. It sets the running entry index to reg_wdata_i[7:0] with bits 1:0 cleared, and it restarts the byte position at red. Bits 31:8 are ignored. Reading word 0 returns {24'b0, running entry index}.
- R4: A write to word 1 consumes reg_wdata_i as four bytes. Bits 31:24 come first and bits 7:0 last, and the bytes cycle red, green, blue. A triple is written to the table at the current index when its blue byte arrives. After an address write, the data words {R0 G0 B0 R1}, {G1 B1 R2 G2}, {B2 R3 G3 B3} fill four consecutive entries.
- R5: Each committed triple advances the running entry index by one, wrapping from 255 to 0.
- R6: Data writes beyond the third continue the byte stream into the following entries without a new address write.
- R7: An address write discards a partly received triple: no table entry is written for it, and the next data byte is taken as red.
- R8: A write to word 2 stores reg_wdata_i[7:0] into the control register selected by the full 8-bit value of the last address write. Reading word 2 returns {24'b0, that register}. A selection of 8 or above makes the write ignored and the read return 0. A control write leaves the entry index, the byte position and the table unchanged.
- R9: A write to word 3 changes neither the table, the entry index, the byte position nor the control registers. Reads of words 1 and 3 return 0.
- R10: pix_rgb_o presents the entry addressed by pix_idx_i one clock after the index is presented. If that entry is written in the same cycle, the old value is returned first and the new value in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_sel_i | input | 2 | Word select: 0 address, 1 color data, 2 control, 3 cursor/overlay |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for the selected word |
| pix_idx_i | input | 8 | Pixel index to look up |
| pix_rgb_o | output | 24 | Looked-up color {red, green, blue}, registered |

## Verification
On every cycle, the assertions check several properties of the index and byte position:
- address writes align the index and reset the byte position;
- each data write steps the byte position and the index by the amount its four bytes imply;
- other cycles leave both untouched.

They also check that the two commit ports of a single word never target the same entry, and that the control bank only changes on an in-range control write.

The actual byte-to-component placement, wrap-around, the discarding of a partial triple and the old-value-on-collision rule of the lookup are shown only by the bench. It compares looked-up colors and readback words against its own model after directed and random streams.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int unsigned COMP_W     = 8;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LANES      = WORD_W / COMP_W;
  localparam int unsigned MAX_COMMIT = (LANES + 2) / 3;
  localparam int unsigned GROUP      = 4;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_CURS = 2'd3;

  localparam logic [1:0] POS_RED   = 2'd0;
  localparam logic [1:0] POS_GREEN = 2'd1;
  localparam logic [1:0] POS_BLUE  = 2'd2;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/clut_unpack.sv
module clut_unpack
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic [1:0]                       pos_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [COMP_W-1:0]                red_i,
  input  logic [COMP_W-1:0]                green_i,
  input  logic [WORD_W-1:0]                word_i,
  output logic [1:0]                       pos_o,
  output logic [IDX_W-1:0]                 idx_o,
  output logic [COMP_W-1:0]                red_o,
  output logic [COMP_W-1:0]                green_o,
  output logic [MAX_COMMIT-1:0]            we_o,
  output logic [MAX_COMMIT-1:0][IDX_W-1:0] widx_o,
  output rgb_t [MAX_COMMIT-1:0]            wdat_o
);
  localparam int unsigned CNT_W = $clog2(MAX_COMMIT + 1);

  always_comb begin
    logic [1:0]        p;
    logic [IDX_W-1:0]  ix;
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] byt;
    logic [CNT_W-1:0]  n;
    p      = pos_i;
    ix     = idx_i;
    r      = red_i;
    g      = green_i;
    n      = '0;
    byt    = '0;
    we_o   = '0;
    widx_o = '0;
    wdat_o = '0;
    // stream order: most significant byte first
    for (int k = 0; k < LANES; k++) begin
      byt = word_i[WORD_W-1-k*COMP_W -: COMP_W];
      case (p)
        POS_RED: begin
          r = byt;
          p = POS_GREEN;
        end
        POS_GREEN: begin
          g = byt;
          p = POS_BLUE;
        end
        default: begin
          we_o[n]   = 1'b1;
          widx_o[n] = ix;
          wdat_o[n] = {r, g, byt};
          n         = n + 1'b1;
          ix        = ix + 1'b1;
          p         = POS_RED;
        end
      endcase
    end
    pos_o   = p;
    idx_o   = ix;
    red_o   = r;
    green_o = g;
  end
endmodule

// File: rtl/clut_table.sv
module clut_table
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned PORTS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PORTS-1:0]            we_i,
  input  logic [PORTS-1:0][IDX_W-1:0] widx_i,
  input  rgb_t [PORTS-1:0]            wdat_i,
  input  logic [IDX_W-1:0]      ridx_i,
  output rgb_t                  rdat_o
);
  localparam int unsigned ENTRIES = 2 ** IDX_W;

  rgb_t mem [ENTRIES];
  rgb_t rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
      rd_q <= '0;
    end else begin
      rd_q <= mem[ridx_i];
      for (int k = 0; k < PORTS; k++) begin
        if (we_i[k]) mem[widx_i[k]] <= wdat_i[k];
      end
    end
  end

  assign rdat_o = rd_q;

  if (PORTS > 1) begin : g_dual_chk
    AST_PORTS_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i[0] && we_i[1]) |-> (widx_i[0] != widx_i[1])); // R5
  end
endmodule

// File: rtl/clut_ctrl_bank.sv
module clut_ctrl_bank #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned SEL_W = 8,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned LW = (NREGS > 1) ? $clog2(NREGS) : 1;

  function automatic logic [REG_W-1:0] init_val(int i);
    case (i)
      4:       return REG_W'(8'hFF);
      6:       return REG_W'(8'h70);
      default: return '0;
    endcase
  endfunction

  logic [NREGS-1:0][REG_W-1:0] regs;
  logic                        in_range;

  assign in_range = (sel_i < SEL_W'(NREGS));

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= init_val(i);
      else if (we_i && (sel_i == SEL_W'(i)))    q <= wdata_i;
    end
    assign regs[i] = q;
  end

  assign rdata_o = in_range ? regs[sel_i[LW-1:0]] : '0;

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs)); // R8
  AST_CTRL_OOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !in_range) |=> $stable(regs)); // R8
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CTRL_REGS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_sel_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic [3*COMP_W-1:0] pix_rgb_o
);
  localparam int unsigned GA = $clog2(GROUP);

  logic [IDX_W-1:0]  ent_q, sel_q;
  logic [1:0]        pos_q;
  logic [COMP_W-1:0] red_q, green_q;

  logic [1:0]        pos_n;
  logic [IDX_W-1:0]  ent_n;
  logic [COMP_W-1:0] red_n, green_n;
  logic [MAX_COMMIT-1:0]            c_we;
  logic [MAX_COMMIT-1:0][IDX_W-1:0] c_idx;
  rgb_t [MAX_COMMIT-1:0]            c_dat;
  logic [MAX_COMMIT-1:0]            t_we;
  rgb_t                             rd_dat;
  logic [COMP_W-1:0]                ctrl_rd;

  logic wr_addr, wr_data, wr_ctrl;
  assign wr_addr = reg_we_i && (reg_sel_i == SEL_ADDR);
  assign wr_data = reg_we_i && (reg_sel_i == SEL_DATA);
  assign wr_ctrl = reg_we_i && (reg_sel_i == SEL_CTRL);

  clut_unpack #(.IDX_W(IDX_W)) i_unpack (
    .pos_i   (pos_q),
    .idx_i   (ent_q),
    .red_i   (red_q),
    .green_i (green_q),
    .word_i  (reg_wdata_i),
    .pos_o   (pos_n),
    .idx_o   (ent_n),
    .red_o   (red_n),
    .green_o (green_n),
    .we_o    (c_we),
    .widx_o  (c_idx),
    .wdat_o  (c_dat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q   <= '0;
      sel_q   <= '0;
      pos_q   <= POS_RED;
      red_q   <= '0;
      green_q <= '0;
    end else if (wr_addr) begin
      sel_q <= reg_wdata_i[IDX_W-1:0];
      ent_q <= {reg_wdata_i[IDX_W-1:GA], GA'(0)};
      pos_q <= POS_RED;
    end else if (wr_data) begin
      ent_q   <= ent_n;
      pos_q   <= pos_n;
      red_q   <= red_n;
      green_q <= green_n;
    end
  end

  assign t_we = wr_data ? c_we : '0;

  clut_table #(.IDX_W(IDX_W), .PORTS(MAX_COMMIT)) i_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (t_we),
    .widx_i (c_idx),
    .wdat_i (c_dat),
    .ridx_i (pix_idx_i),
    .rdat_o (rd_dat)
  );

  clut_ctrl_bank #(.NREGS(CTRL_REGS), .SEL_W(IDX_W), .REG_W(COMP_W)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ctrl),
    .sel_i   (sel_q),
    .wdata_i (reg_wdata_i[COMP_W-1:0]),
    .rdata_o (ctrl_rd)
  );

  assign pix_rgb_o = rd_dat;

  always_comb begin
    case (reg_sel_i)
      SEL_ADDR: reg_rdata_o = {{(WORD_W-IDX_W){1'b0}}, ent_q};
      SEL_CTRL: reg_rdata_o = {{(WORD_W-COMP_W){1'b0}}, ctrl_rd};
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_ADDR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr |=> (ent_q == {$past(reg_wdata_i[IDX_W-1:GA]), GA'(0)}) && (pos_q == POS_RED)); // R3
  AST_POS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q != 2'd3); // R4
  AST_POS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> pos_q == (($past(pos_q) == POS_BLUE) ? POS_RED : $past(pos_q) + 2'd1)); // R4
  AST_ENT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> ent_q == $past(ent_q) + (($past(pos_q) == POS_BLUE) ? IDX_W'(2) : IDX_W'(1))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_addr || wr_data) |=> $stable(ent_q) && $stable(pos_q)); // R9
endmodule

// File: tb/test_clut_loader.sv
module test_clut_loader;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [7:0]  pix_idx_i = '0;
  logic [23:0] pix_rgb_o;

  always #2 clk_i = ~clk_i;

  clut_loader i_clut_loader (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .reg_rdata_o, .pix_idx_i, .pix_rgb_o
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [23:0] exp_tab [256];
  logic [7:0]  exp_ctrl [8];
  logic [7:0]  m_ent, m_sel, m_r, m_g;
  int          m_pos;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mdl(logic [1:0] sel, logic [31:0] d);
    logic [7:0] b;
    case (sel)
      2'd0: begin m_sel = d[7:0]; m_ent = {d[7:2], 2'b00}; m_pos = 0; end
      2'd1: for (int k = 0; k < 4; k++) begin
        b = d[31-8*k -: 8];
        if (m_pos == 0) begin m_r = b; m_pos = 1; end
        else if (m_pos == 1) begin m_g = b; m_pos = 2; end
        else begin exp_tab[m_ent] = {m_r, m_g, b}; m_ent = m_ent + 8'd1; m_pos = 0; end
      end
      2'd2: if (m_sel < 8) exp_ctrl[m_sel[2:0]] = d[7:0];
      default: ;
    endcase
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    mdl(sel, d);
  endtask

  task automatic rd(string tag, logic [1:0] sel, logic [31:0] exp);
    reg_sel_i = sel;
    @(negedge clk_i);
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic look(string tag, logic [7:0] idx);
    pix_idx_i = idx;
    @(negedge clk_i);
    check(tag, {8'h00, pix_rgb_o}, {8'h00, exp_tab[idx]});
  endtask

  task automatic ctrl_sweep(string tag);
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, i);
      rd(tag, 2'd2, {24'h0, exp_ctrl[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] old;
    logic [1:0]  s;
    void'($urandom(32'h5eed_c1a7));
    for (int i = 0; i < 256; i++) exp_tab[i] = '0;
    for (int i = 0; i < 8; i++) exp_ctrl[i] = 8'h00;
    exp_ctrl[4] = 8'hFF; exp_ctrl[6] = 8'h70;
    m_ent = 0; m_sel = 0; m_pos = 0; m_r = 0; m_g = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1
    check("R1 pix after reset", {8'h0, pix_rgb_o}, 32'h0);
    rd("R1 index after reset", 2'd0, 32'h0);
    look("R1 entry 0", 8'd0);
    look("R1 entry 255", 8'd255);
    // R2
    ctrl_sweep("R2 control reset value");
    // R3
    wr(2'd0, 32'hFFFF_FF37);
    rd("R3 aligned index", 2'd0, 32'h34);
    // R4 directed group
    wr(2'd0, 32'd8);
    wr(2'd1, 32'h0102_0304);
    wr(2'd1, 32'h0506_0708);
    wr(2'd1, 32'h090A_0B0C);
    rd("R4 index after group", 2'd0, 32'd12);
    look("R4 entry 8", 8'd8);
    check("R4 entry 9 value", {8'h0, exp_tab[9]}, 32'h040506);
    look("R4 entry 9", 8'd9);
    look("R4 entry 10", 8'd10);
    look("R4 entry 11", 8'd11);
    look("R4 entry 12 untouched", 8'd12);
    // R5 wrap, R6 continuation
    wr(2'd0, 32'd252);
    wr(2'd1, 32'hA1A2_A3A4); wr(2'd1, 32'hA5A6_A7A8); wr(2'd1, 32'hA9AA_ABAC);
    rd("R5 index wraps to 0", 2'd0, 32'd0);
    look("R5 entry 255", 8'd255);
    wr(2'd1, 32'hB1B2_B3B4); wr(2'd1, 32'hB5B6_B7B8); wr(2'd1, 32'hB9BA_BBBC);
    rd("R6 index after continuation", 2'd0, 32'd4);
    look("R6 entry 0", 8'd0);
    look("R6 entry 3", 8'd3);
    // R7 partial triple discarded
    wr(2'd0, 32'd40);
    wr(2'd1, 32'h1122_3344);
    wr(2'd0, 32'd44);
    wr(2'd1, 32'h5566_7788);
    look("R7 entry 40", 8'd40);
    look("R7 entry 41 untouched", 8'd41);
    look("R7 entry 44 starts at red", 8'd44);
    // R8 control write
    wr(2'd0, 32'd5);
    wr(2'd2, 32'h1234_565A);
    rd("R8 control readback", 2'd2, 32'h5A);
    rd("R8 index unaffected", 2'd0, 32'd4);
    wr(2'd0, 32'd200);
    wr(2'd2, 32'h0000_0099);
    rd("R8 out of range read", 2'd2, 32'h0);
    ctrl_sweep("R8 out of range ignored");
    // R9 cursor word
    wr(2'd0, 32'd60);
    wr(2'd1, 32'hC1C2_C3C4);
    wr(2'd3, 32'hDEAD_BEEF);
    rd("R9 index unchanged", 2'd0, 32'd61);
    rd("R9 word 3 reads 0", 2'd3, 32'h0);
    rd("R9 word 1 reads 0", 2'd1, 32'h0);
    wr(2'd1, 32'hC5C6_C7C8);
    look("R9 stream intact 61", 8'd61);
    look("R9 entry 62 stream intact", 8'd62);
    // R10 same-cycle write and lookup
    wr(2'd0, 32'd100);
    old = exp_tab[100];
    pix_idx_i = 8'd100;
    reg_we_i = 1'b1; reg_sel_i = 2'd1; reg_wdata_i = 32'hAABB_CCDD;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    check("R10 old value on collision", {8'h0, pix_rgb_o}, {8'h0, old});
    mdl(2'd1, 32'hAABB_CCDD);
    @(negedge clk_i);
    check("R10 new value next cycle", {8'h0, pix_rgb_o}, {8'h0, exp_tab[100]});
    // random streams (R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 600; i++) begin
      int w;
      w = $urandom_range(0, 9);
      s = (w < 1) ? 2'd0 : (w < 8) ? 2'd1 : (w < 9) ? 2'd2 : 2'd3;
      pix_idx_i = 8'($urandom);
      wr(s, $urandom);
    end
    rd("R5 random index", 2'd0, {24'h0, m_ent});
    for (int i = 0; i < 256; i++) look("R4 random sweep", 8'(i));
    ctrl_sweep("R8 random control");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule